// File: doc/BRIEF.md
# DCC Track Packet Serializer

This block turns a short command packet into the two-rail bit stream of a DCC model railway track signal. A packet has 1 to 6 bytes: an address byte followed by instruction bytes. It is presented on a parallel input, with byte 0 (the address) in bits [7:0], byte 1 in bits [15:8], and so on. The block sends a preamble of one-bits. It then sends every byte, and after them a check byte that it computes itself. Each byte is preceded by a zero bit and sent most significant bit first. A single one-bit closes the packet. Every bit is made of two equal half-periods. A one-bit uses the short half-period and a zero-bit the long one. Each half-period is counted in pulses of a tick input, not in clock cycles, so the bit timing does not depend on the clock frequency.

The packet inputs are sampled only at the clock edge where the closing bit of the current packet ends, and that sampled packet is sent next. A one-cycle request pulse in the following cycle tells the supplier that its packet was taken and that the next packet may be presented. The block sends an idle packet in three cases: the valid input is low at that edge, the length is out of range, or the block has just left reset.

Top module: `dcc_serializer`

## Requirements
- R1: During reset and in the first cycle after it, rail_a_o is 1, rail_b_o is 0 and pkt_req_o is 0. The first packet sent after reset is the idle packet.
- R2: rail_b_o is always the inverse of rail_a_o.
- R3: Each packet starts with exactly PRE_BITS one-bits (default 14), followed by a zero bit.
- R4: Every byte is preceded by one zero bit and sent most significant bit first. After the check byte, a single one-bit ends the packet.
- R5: The last byte sent is the XOR of all address and instruction bytes of the packet.
- R6: Both half-periods of a bit have the same length. That length is ONE_HALF tick pulses (default 58) for a one-bit and ZERO_HALF tick pulses (default 100) for a zero-bit. With one tick every two clocks, every half-period lasts twice as many clock cycles.
- R7: pkt_req_o is high for exactly one cycle, in the cycle after the clock edge where a packet's closing bit ends. It happens once per packet.
- R8: If pkt_valid_i is low at the sampling edge, the next packet is the idle packet: bytes 0xFF and 0x00, then check byte 0xFF.
- R9: A pkt_len_i of 0, or a value above MAX_BYTES (6), gives the idle packet, whatever the data input holds.
- R10: Changes to the packet inputs after the sampling edge do not alter the packet being sent.
- R11: pkt_len_i = n (1 to 6) sends bytes 0 to n-1 from pkt_data_i[8*i +: 8], in increasing order of i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse; each high cycle counts one unit of a half-period |
| pkt_valid_i | input | 1 | A packet is presented on pkt_len_i and pkt_data_i |
| pkt_len_i | input | 3 | Number of address plus instruction bytes, 1 to MAX_BYTES |
| pkt_data_i | input | 48 | Packet bytes, byte i in bits [8*i+7:8*i] |
| pkt_req_o | output | 1 | One-cycle pulse: packet inputs were taken, present the next |
| rail_a_o | output | 1 | Rail A drive |
| rail_b_o | output | 1 | Rail B drive, opposite of rail A |

## Verification
Each rail edge is due exactly one half-period after the previous one: the half-period length in ticks, times the tick spacing in clocks. The decoder in the bench times each interval from the cycle where reset is released, samples on the falling clock edge, and rebuilds bits, bytes and preamble lengths from the measured intervals. The packet that follows is taken at the rising edge that ends the closing bit. pkt_req_o must be high at the same falling-edge sample where that final rail edge is seen. The driver changes the packet inputs only after seeing that pulse, and it fills them with junk for a while before presenting the next vector. It switches the tick spacing in the same cycle, so the first half-period of the next packet already runs on the new timebase.

// File: rtl/dcc_ser_pkg.sv
package dcc_ser_pkg;
  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_SEP  = 2'd1,
    ST_DATA = 2'd2,
    ST_END  = 2'd3
  } frame_st_e;

  localparam logic [7:0] IDLE_ADDR = 8'hFF;
  localparam logic [7:0] IDLE_DATA = 8'h00;
endpackage

// File: rtl/dcc_half_timer.sv
module dcc_half_timer #(
  parameter int ONE_HALF  = 58,
  parameter int ZERO_HALF = 100,
  localparam int HALF_MAX = (ONE_HALF > ZERO_HALF) ? ONE_HALF : ZERO_HALF,
  localparam int CNT_W    = $clog2(HALF_MAX)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bit_val_i,
  output logic bit_done_o,
  output logic rail_a_o,
  output logic rail_b_o
);
  localparam logic [CNT_W-1:0] ONE_LAST  = CNT_W'(ONE_HALF - 1);
  localparam logic [CNT_W-1:0] ZERO_LAST = CNT_W'(ZERO_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             rail_a_q, rail_b_q;
  logic             half_last;

  assign half_last  = (cnt_q == (bit_val_i ? ONE_LAST : ZERO_LAST));
  assign bit_done_o = tick_i & half_last & phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      rail_a_q <= 1'b1;
      rail_b_q <= 1'b0;
    end else if (tick_i) begin
      if (half_last) begin
        cnt_q    <= '0;
        phase_q  <= ~phase_q;
        rail_a_q <= ~rail_a_q;
        rail_b_q <= ~rail_b_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rail_a_o = rail_a_q;
  assign rail_b_o = rail_b_q;

  // rails move only on a counted tick
  assert_edge_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_a_q != $past(rail_a_q)) |-> $past(tick_i));

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ZERO_LAST || cnt_q <= ONE_LAST);

  assert_rails_opposite_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rail_a_q != rail_b_q);
endmodule

// File: rtl/dcc_pkt_buf.sv
module dcc_pkt_buf
  import dcc_ser_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   valid_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [8*MAX_BYTES-1:0] data_i,
  input  logic [LEN_W-1:0]       idx_i,
  output logic [LEN_W-1:0]       len_o,
  output logic [7:0]             byte_o
);
  logic [MAX_BYTES-1:0][7:0] bytes_q;
  logic [LEN_W-1:0]          len_q;
  logic                      len_ok;
  logic [7:0]                chk;
  logic [7:0]                sel;

  assign len_ok = valid_i && (len_i != '0) && (len_i <= LEN_W'(MAX_BYTES));

  // bytes past the length are zeroed so the check is a flat XOR
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= LEN_W'(2);
      for (int i = 0; i < MAX_BYTES; i++)
        bytes_q[i] <= (i == 0) ? IDLE_ADDR : IDLE_DATA;
    end else if (load_i) begin
      len_q <= len_ok ? len_i : LEN_W'(2);
      for (int i = 0; i < MAX_BYTES; i++) begin
        if (len_ok)
          bytes_q[i] <= (LEN_W'(i) < len_i) ? data_i[8*i +: 8] : 8'h00;
        else
          bytes_q[i] <= (i == 0) ? IDLE_ADDR : IDLE_DATA;
      end
    end
  end

  always_comb begin
    chk = 8'h00;
    sel = 8'h00;
    for (int i = 0; i < MAX_BYTES; i++) begin
      chk = chk ^ bytes_q[i];
      if (LEN_W'(i) == idx_i) sel = bytes_q[i];
    end
  end

  assign byte_o = (idx_i == len_q) ? chk : sel;
  assign len_o  = len_q;

  assert_hold_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != $past(len_q)) |-> $past(load_i));

  assert_hold_bytes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bytes_q != $past(bytes_q)) |-> $past(load_i));

  assert_idle_sub_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !valid_i) |=> (len_q == LEN_W'(2) && bytes_q[0] == IDLE_ADDR && bytes_q[1] == IDLE_DATA));

  assert_len_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0) && (len_q <= LEN_W'(MAX_BYTES)));
endmodule

// File: rtl/dcc_frame_seq.sv
module dcc_frame_seq
  import dcc_ser_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int PRE_BITS  = 14,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int PRE_W    = $clog2(PRE_BITS),
  localparam int A_W      = $clog2(PRE_BITS + 9 * (MAX_BYTES + 1) + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_done_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [7:0]       cur_byte_i,
  output logic [LEN_W-1:0] byte_idx_o,
  output logic             bit_val_o,
  output logic             load_o,
  output logic             req_o
);
  frame_st_e        state_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [2:0]       bit_idx_q;
  logic [LEN_W-1:0] byte_idx_q;
  logic             req_q;

  always_comb begin
    case (state_q)
      ST_PRE:  bit_val_o = 1'b1;
      ST_SEP:  bit_val_o = 1'b0;
      ST_DATA: bit_val_o = cur_byte_i[3'd7 - bit_idx_q];
      default: bit_val_o = 1'b1;
    endcase
  end

  assign load_o = bit_done_i && (state_q == ST_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PRE;
      pre_cnt_q  <= '0;
      bit_idx_q  <= '0;
      byte_idx_q <= '0;
    end else if (bit_done_i) begin
      case (state_q)
        ST_PRE: begin
          if (pre_cnt_q == PRE_W'(PRE_BITS - 1)) begin
            pre_cnt_q <= '0;
            state_q   <= ST_SEP;
          end else begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
          end
        end
        ST_SEP: begin
          bit_idx_q <= '0;
          state_q   <= ST_DATA;
        end
        ST_DATA: begin
          if (bit_idx_q == 3'd7) begin
            bit_idx_q <= '0;
            if (byte_idx_q == pkt_len_i) begin
              state_q <= ST_END;
            end else begin
              byte_idx_q <= byte_idx_q + 1'b1;
              state_q    <= ST_SEP;
            end
          end else begin
            bit_idx_q <= bit_idx_q + 1'b1;
          end
        end
        default: begin
          byte_idx_q <= '0;
          state_q    <= ST_PRE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= load_o;
  end

  assign req_o      = req_q;
  assign byte_idx_o = byte_idx_q;

  // independent bit count since the packet was latched
  logic [A_W-1:0] a_bits_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         a_bits_q <= '0;
    else if (load_o)     a_bits_q <= '0;
    else if (bit_done_i) a_bits_q <= a_bits_q + 1'b1;
  end

  assert_preamble_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEP && byte_idx_q == '0) |-> (a_bits_q == A_W'(PRE_BITS)));

  assert_end_after_check_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_END) |-> (byte_idx_q == pkt_len_i));

  assert_req_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
endmodule

// File: rtl/dcc_serializer.sv
module dcc_serializer #(
  parameter int MAX_BYTES = 6,
  parameter int PRE_BITS  = 14,
  parameter int ONE_HALF  = 58,
  parameter int ZERO_HALF = 100,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   pkt_valid_i,
  input  logic [LEN_W-1:0]       pkt_len_i,
  input  logic [8*MAX_BYTES-1:0] pkt_data_i,
  output logic                   pkt_req_o,
  output logic                   rail_a_o,
  output logic                   rail_b_o
);
  logic             bit_done;
  logic             bit_val;
  logic             load;
  logic [LEN_W-1:0] byte_idx;
  logic [LEN_W-1:0] buf_len;
  logic [7:0]       cur_byte;

  dcc_pkt_buf #(.MAX_BYTES(MAX_BYTES)) i_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .valid_i (pkt_valid_i),
    .len_i   (pkt_len_i),
    .data_i  (pkt_data_i),
    .idx_i   (byte_idx),
    .len_o   (buf_len),
    .byte_o  (cur_byte)
  );

  dcc_frame_seq #(.MAX_BYTES(MAX_BYTES), .PRE_BITS(PRE_BITS)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_done_i (bit_done),
    .pkt_len_i  (buf_len),
    .cur_byte_i (cur_byte),
    .byte_idx_o (byte_idx),
    .bit_val_o  (bit_val),
    .load_o     (load),
    .req_o      (pkt_req_o)
  );

  dcc_half_timer #(.ONE_HALF(ONE_HALF), .ZERO_HALF(ZERO_HALF)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .bit_val_i  (bit_val),
    .bit_done_o (bit_done),
    .rail_a_o   (rail_a_o),
    .rail_b_o   (rail_b_o)
  );

  // a request follows the rail edge that closes a packet
  assert_req_after_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_req_o |-> (rail_a_o != $past(rail_a_o)));
endmodule

// File: tb/test_dcc_serializer.sv
`timescale 1ns/1ps
module test_dcc_serializer;
  localparam int NPKT  = 12;
  localparam int NSTEP = 11;
  localparam int ONE_T = 58;
  localparam int ZERO_T = 100;
  localparam int RXN   = 16;

  // {div2, valid, len, data}
  localparam logic [52:0] STEPS [NSTEP] = '{
    {1'b0, 1'b1, 3'd2, 48'h0000_0000_7603},
    {1'b0, 1'b1, 3'd2, 48'h0000_0000_0000},
    {1'b0, 1'b1, 3'd1, 48'h0000_0000_00A5},
    {1'b0, 1'b1, 3'd6, 48'hAB89_6745_23C1},
    {1'b0, 1'b1, 3'd4, 48'h0000_00FF_00FF},
    {1'b0, 1'b1, 3'd5, 48'h0055_FE01_7F80},
    {1'b0, 1'b1, 3'd0, 48'h1122_3344_5566},
    {1'b0, 1'b1, 3'd7, 48'h1122_3344_5566},
    {1'b0, 1'b0, 3'd3, 48'h0000_00DE_ADBE},
    {1'b1, 1'b1, 3'd1, 48'h0000_0000_00A5},
    {1'b0, 1'b0, 3'd2, 48'h0000_0000_0000}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        pkt_valid_i;
  logic [2:0]  pkt_len_i;
  logic [47:0] pkt_data_i;
  logic        pkt_req_o, rail_a_o, rail_b_o;

  dcc_serializer i_dcc_serializer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .pkt_valid_i(pkt_valid_i), .pkt_len_i(pkt_len_i), .pkt_data_i(pkt_data_i),
    .pkt_req_o(pkt_req_o), .rail_a_o(rail_a_o), .rail_b_o(rail_b_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected packets
  logic [7:0] exp_b [NPKT][8];
  int         exp_n [NPKT];
  int         exp_s [NPKT];
  int         exp_cnt = 0;

  task automatic push_exp(input logic v, input logic [2:0] l, input logic [47:0] d, input int s);
    logic [7:0] x;
    int n;
    if (exp_cnt < NPKT) begin
      x = 8'h00;
      if (v && l >= 3'd1 && l <= 3'd6) begin
        n = int'(l);
        for (int j = 0; j < n; j++) begin
          exp_b[exp_cnt][j] = d[8*j +: 8];
          x = x ^ d[8*j +: 8];
        end
      end else begin
        n = 2;
        exp_b[exp_cnt][0] = 8'hFF;
        exp_b[exp_cnt][1] = 8'h00;
        x = 8'hFF;
      end
      exp_b[exp_cnt][n] = x;
      exp_n[exp_cnt] = n + 1;
      exp_s[exp_cnt] = s;
      exp_cnt++;
    end
  endtask

  // driver
  int   cur = 0;
  int   gap = 0;
  logic mode2 = 1'b0;
  logic tick_ph = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (pkt_req_o) begin
        if (cur < NSTEP) begin
          push_exp(STEPS[cur][51], STEPS[cur][50:48], STEPS[cur][47:0], STEPS[cur][52] ? 2 : 1);
          mode2   <= STEPS[cur][52];
          tick_i  <= STEPS[cur][52] ? 1'b0 : 1'b1;
        end else begin
          push_exp(1'b0, 3'd0, 48'h0, 1);
          mode2  <= 1'b0;
          tick_i <= 1'b1;
        end
        tick_ph     <= 1'b1;
        cur         <= cur + 1;
        pkt_valid_i <= 1'b1;
        pkt_len_i   <= 3'd6;
        pkt_data_i  <= 48'hA5A5_5A5A_C3C3;
        gap         <= 300;
      end else begin
        if (mode2) begin
          tick_i  <= tick_ph;
          tick_ph <= ~tick_ph;
        end else begin
          tick_i <= 1'b1;
        end
        if (gap > 0) begin
          gap <= gap - 1;
          if (gap == 1) begin
            if (cur < NSTEP) begin
              pkt_valid_i <= STEPS[cur][51];
              pkt_len_i   <= STEPS[cur][50:48];
              pkt_data_i  <= STEPS[cur][47:0];
            end else begin
              pkt_valid_i <= 1'b0;
            end
          end
        end
      end
    end
  end

  // rail decoder
  logic [7:0] rx_b [RXN][8];
  int  rx_n [RXN];
  int  rx_pre [RXN];
  int  rx_s [RXN];
  int  rx_cnt = 0;
  int  cyc = 0, h1 = 0, ones = 0, nbit = 0, nb = 0, pscale = -1;
  int  dstate = 0;
  bit  have1 = 0;
  logic last_a = 1'b1;
  logic [7:0] sr = 8'h00;
  int  cmp_bad = 0, half_bad = 0, req_bad = 0;

  always @(negedge clk) begin
    bit done_now;
    int h, s, b;
    done_now = 0;
    if (rst_ni) begin
      if (rail_a_o == rail_b_o) cmp_bad++;
      cyc++;
      if (rail_a_o != last_a) begin
        last_a = rail_a_o;
        h = cyc;
        cyc = 0;
        if (!have1) begin
          h1 = h;
          have1 = 1;
        end else begin
          have1 = 0;
          if (h != h1) half_bad++;
          b = -1; s = 0;
          if (h1 == ONE_T)       begin b = 1; s = 1; end
          else if (h1 == 2*ONE_T)  begin b = 1; s = 2; end
          else if (h1 == ZERO_T)   begin b = 0; s = 1; end
          else if (h1 == 2*ZERO_T) begin b = 0; s = 2; end
          else half_bad++;
          if (b >= 0) begin
            if (pscale == -1) pscale = s;
            else if (pscale != s) pscale = 0;
            case (dstate)
              0: begin
                if (b == 1) ones++;
                else begin
                  if (rx_cnt < RXN) rx_pre[rx_cnt] = ones;
                  dstate = 1; nbit = 0; nb = 0;
                end
              end
              1: begin
                sr = {sr[6:0], b[0]};
                nbit++;
                if (nbit == 8) begin
                  if (rx_cnt < RXN && nb < 8) rx_b[rx_cnt][nb] = sr;
                  nb++;
                  nbit = 0;
                  dstate = 2;
                end
              end
              default: begin
                if (b == 0) dstate = 1;
                else begin
                  if (rx_cnt < RXN) begin
                    rx_n[rx_cnt] = nb;
                    rx_s[rx_cnt] = pscale;
                  end
                  rx_cnt++;
                  done_now = 1;
                  ones = 0;
                  pscale = -1;
                  dstate = 0;
                end
              end
            endcase
          end
        end
      end
      if (done_now != pkt_req_o) req_bad++;
    end
  end

  function automatic string tag_of(input int i);
    if (i == 0) return "R1";
    if (i == 7 || i == 8) return "R9";
    if (i == 9 || i == 11) return "R8";
    return "R11";
  endfunction

  bit timeout = 0;

  initial begin
    pkt_valid_i = STEPS[0][51];
    pkt_len_i   = STEPS[0][50:48];
    pkt_data_i  = STEPS[0][47:0];
    push_exp(1'b0, 3'd0, 48'h0, 1); // packet after reset is idle
    repeat (3) @(negedge clk);
    chk(rail_a_o == 1'b1, "R1", "rail_a in reset", int'(rail_a_o), 1);
    chk(rail_b_o == 1'b0, "R1", "rail_b in reset", int'(rail_b_o), 0);
    chk(pkt_req_o == 1'b0, "R1", "req in reset", int'(pkt_req_o), 0);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(rail_a_o == 1'b1 && rail_b_o == 1'b0, "R1", "rails after reset", int'({rail_a_o, rail_b_o}), 2);
    chk(pkt_req_o == 1'b0, "R1", "req after reset", int'(pkt_req_o), 0);

    fork
      wait (rx_cnt >= NPKT);
      begin
        repeat (190000) @(posedge clk);
        timeout = 1;
      end
    join_any
    @(negedge clk);

    chk(!timeout, "R7", "watchdog packets seen", rx_cnt, NPKT);
    for (int i = 0; i < NPKT; i++) begin
      if (i < rx_cnt && i < exp_cnt) begin
        chk(rx_pre[i] == 14, "R3", $sformatf("preamble pkt %0d", i), rx_pre[i], 14);
        chk(rx_n[i] == exp_n[i], {tag_of(i), " R4"}, $sformatf("byte count pkt %0d", i), rx_n[i], exp_n[i]);
        for (int j = 0; j < exp_n[i] && j < 8; j++) begin
          if (j == exp_n[i] - 1)
            chk(rx_b[i][j] == exp_b[i][j], "R5", $sformatf("check byte pkt %0d", i), int'(rx_b[i][j]), int'(exp_b[i][j]));
          else
            chk(rx_b[i][j] == exp_b[i][j], {tag_of(i), " R4 R10"}, $sformatf("pkt %0d byte %0d", i, j), int'(rx_b[i][j]), int'(exp_b[i][j]));
        end
        chk(rx_s[i] == exp_s[i], "R6", $sformatf("tick scale pkt %0d", i), rx_s[i], exp_s[i]);
      end
    end
    chk(cmp_bad == 0, "R2", "rails equal samples", cmp_bad, 0);
    chk(half_bad == 0, "R6", "bad half-periods", half_bad, 0);
    chk(req_bad == 0, "R7", "req misaligned samples", req_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule